// File: doc/BRIEF.md
# Dual-Group General-Purpose Pin Controller

This block drives and senses two groups of general-purpose pins through a small register bus. The first group is open-drain. Its pins can only sink current or float. The second group is push-pull tri-state, and each of its pins also has a switchable pull-up.

Each group has two per-pin registers: a data register and a direction register. One control register holds a single global pull-up enable. On a push-pull pin, the data bit sets the driven level. The same data bit also chooses whether that pin's pull-up turns on while the global enable is set.

The incoming pin levels of both groups pass through a two-flop synchronizer before software reads them. Each push-pull pin can be handed to a peripheral, which then supplies its output level and its output enable. The pull-up setting stays under register control even for a handed-over pin.

Top module: `gpio_port`

## Requirements
- R1: After reset, every direction bit is 0, every data bit is 1 and the global pull-up enable is 0. So all output enables and all pull-up enables are 0.
- R2: A write strobe lasting one cycle updates the addressed register at that clock edge. Reads are combinational, zero-extended to the bus width. The address map is: 0 = open-drain data, 1 = open-drain direction, 2 = push-pull data, 3 = push-pull direction, 4 = open-drain pin level, 5 = push-pull pin level, 6 = control (bit 0 is the global pull-up enable).
- R3: A direction bit of 1 makes its pin an output, and a direction bit of 0 releases the pin's output enable.
- R4: An open-drain pin is enabled only when its direction bit is 1 and its data bit is 0, and its output value is always 0. It never drives high.
- R5: A push-pull pin that is not handed to a peripheral drives its data bit as its output value.
- R6: A push-pull pin's pull-up enable equals the global enable AND that pin's data bit, whatever the pin's direction.
- R7: While the global enable is 0, every pull-up enable is 0, whatever the data bits hold.
- R8: A push-pull pin with its peripheral-select bit set takes its output value and output enable from the peripheral inputs. Its pull-up enable is unaffected by the select.
- R9: Reading a pin-level address returns the pin inputs as they stood two clock edges earlier. A change first shows after the second edge.
- R10: Writes to the pin-level addresses and to address 7 change no register, and address 7 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | One-cycle write strobe |
| addr | input | 3 | Register address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Combinational read data |
| odPinIn | input | OD_W | Open-drain pin levels |
| odOutVal | output | OD_W | Open-drain output values (always low) |
| odOutEn | output | OD_W | Open-drain sink enables |
| ppPinIn | input | PP_W | Push-pull pin levels |
| ppPeriphSel | input | PP_W | Per-pin hand-over to the peripheral |
| ppPeriphVal | input | PP_W | Peripheral output values |
| ppPeriphEn | input | PP_W | Peripheral output enables |
| ppOutVal | output | PP_W | Push-pull output values |
| ppOutEn | output | PP_W | Push-pull output enables |
| ppPullEn | output | PP_W | Push-pull pull-up enables |

## Verification
The bench builds the block with three open-drain pins, four push-pull pins and an 8-bit bus. At these widths a full sweep is cheap. It covers every data and direction pattern of the push-pull group under both settings of the global enable, and every pattern of the open-drain group. Each expected output is computed bitwise from the rules. The narrow 8-bit bus also lets the bench confirm that the upper read bits are zero-filled and that unmapped writes change nothing.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADR_OD_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_OD_DIR  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_PP_DATA = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_PP_DIR  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_OD_PIN  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_PP_PIN  = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_CTRL    = 3'd6;

  typedef struct packed {
    logic odData;
    logic odDir;
    logic ppData;
    logic ppDir;
    logic ctrl;
  } gpio_wr_t;

  typedef enum logic [2:0] {
    RD_OD_DATA, RD_OD_DIR, RD_PP_DATA, RD_PP_DIR,
    RD_OD_PIN, RD_PP_PIN, RD_CTRL, RD_NONE
  } gpio_rd_e;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output gpio_wr_t          wrStb,
  output gpio_rd_e          rdSel
);
  always_comb begin
    wrStb        = '0;
    wrStb.odData = wrEn && (addr == ADR_OD_DATA);
    wrStb.odDir  = wrEn && (addr == ADR_OD_DIR);
    wrStb.ppData = wrEn && (addr == ADR_PP_DATA);
    wrStb.ppDir  = wrEn && (addr == ADR_PP_DIR);
    wrStb.ctrl   = wrEn && (addr == ADR_CTRL);
  end

  always_comb begin
    case (addr)
      ADR_OD_DATA: rdSel = RD_OD_DATA;
      ADR_OD_DIR:  rdSel = RD_OD_DIR;
      ADR_PP_DATA: rdSel = RD_PP_DATA;
      ADR_PP_DIR:  rdSel = RD_PP_DIR;
      ADR_OD_PIN:  rdSel = RD_OD_PIN;
      ADR_PP_PIN:  rdSel = RD_PP_PIN;
      ADR_CTRL:    rdSel = RD_CTRL;
      default:     rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int OD_W   = 4,
  parameter int PP_W   = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  gpio_wr_t          wrStb,
  input  gpio_rd_e          rdSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [OD_W-1:0]   odPinIn,
  output logic [OD_W-1:0]   odOutVal,
  output logic [OD_W-1:0]   odOutEn,
  input  logic [PP_W-1:0]   ppPinIn,
  input  logic [PP_W-1:0]   ppPeriphSel,
  input  logic [PP_W-1:0]   ppPeriphVal,
  input  logic [PP_W-1:0]   ppPeriphEn,
  output logic [PP_W-1:0]   ppOutVal,
  output logic [PP_W-1:0]   ppOutEn,
  output logic [PP_W-1:0]   ppPullEn
);
  logic [OD_W-1:0] odData, odDir, odLevel;
  logic [PP_W-1:0] ppData, ppDir, ppLevel;
  logic            pullGlobal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      odData     <= '1;
      odDir      <= '0;
      ppData     <= '1;
      ppDir      <= '0;
      pullGlobal <= 1'b0;
    end else begin
      if (wrStb.odData) odData     <= wrData[OD_W-1:0];
      if (wrStb.odDir)  odDir      <= wrData[OD_W-1:0];
      if (wrStb.ppData) ppData     <= wrData[PP_W-1:0];
      if (wrStb.ppDir)  ppDir      <= wrData[PP_W-1:0];
      if (wrStb.ctrl)   pullGlobal <= wrData[0];
    end
  end

  gpio_sync #(.WIDTH(OD_W)) u_odSync (.clk(clk), .rstN(rstN), .din(odPinIn), .dout(odLevel));
  gpio_sync #(.WIDTH(PP_W)) u_ppSync (.clk(clk), .rstN(rstN), .din(ppPinIn), .dout(ppLevel));

  // Open-drain: sink only when output and data is low.
  assign odOutVal = '0;
  assign odOutEn  = odDir & ~odData;

  // Push-pull: per-pin choice between register path and peripheral path.
  for (genvar i = 0; i < PP_W; i++) begin : g_pp
    assign ppOutVal[i] = ppPeriphSel[i] ? ppPeriphVal[i] : ppData[i];
    assign ppOutEn[i]  = ppPeriphSel[i] ? ppPeriphEn[i]  : ppDir[i];
    assign ppPullEn[i] = pullGlobal & ppData[i];
  end

  always_comb begin
    rdData = '0;
    case (rdSel)
      RD_OD_DATA: rdData[OD_W-1:0] = odData;
      RD_OD_DIR:  rdData[OD_W-1:0] = odDir;
      RD_PP_DATA: rdData[PP_W-1:0] = ppData;
      RD_PP_DIR:  rdData[PP_W-1:0] = ppDir;
      RD_OD_PIN:  rdData[OD_W-1:0] = odLevel;
      RD_PP_PIN:  rdData[PP_W-1:0] = ppLevel;
      RD_CTRL:    rdData[0]        = pullGlobal;
      default:    rdData           = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int OD_W   = 4,
  parameter int PP_W   = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [OD_W-1:0]   odPinIn,
  output logic [OD_W-1:0]   odOutVal,
  output logic [OD_W-1:0]   odOutEn,
  input  logic [PP_W-1:0]   ppPinIn,
  input  logic [PP_W-1:0]   ppPeriphSel,
  input  logic [PP_W-1:0]   ppPeriphVal,
  input  logic [PP_W-1:0]   ppPeriphEn,
  output logic [PP_W-1:0]   ppOutVal,
  output logic [PP_W-1:0]   ppOutEn,
  output logic [PP_W-1:0]   ppPullEn
);
  gpio_wr_t wrStb;
  gpio_rd_e rdSel;

  gpio_ctrl u_ctrl (.wrEn(wrEn), .addr(addr), .wrStb(wrStb), .rdSel(rdSel));

  gpio_datapath #(.OD_W(OD_W), .PP_W(PP_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .rdSel(rdSel),
    .wrData(wrData), .rdData(rdData),
    .odPinIn(odPinIn), .odOutVal(odOutVal), .odOutEn(odOutEn),
    .ppPinIn(ppPinIn), .ppPeriphSel(ppPeriphSel), .ppPeriphVal(ppPeriphVal),
    .ppPeriphEn(ppPeriphEn), .ppOutVal(ppOutVal), .ppOutEn(ppOutEn),
    .ppPullEn(ppPullEn)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int OD_W   = 4,
  parameter int PP_W   = 8,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [2:0]        addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic [OD_W-1:0]   odPinIn,
  input logic [OD_W-1:0]   odOutEn,
  input logic [PP_W-1:0]   ppPeriphSel,
  input logic [PP_W-1:0]   ppOutEn,
  input logic [PP_W-1:0]   ppPullEn
);
  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  a_r3_dir_write: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd3) |=>
      ((ppOutEn & ~ppPeriphSel) == ($past(wrData[PP_W-1:0]) & ~ppPeriphSel)));

  a_r4_od_float_on_one: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd0) |=> ((odOutEn & $past(wrData[OD_W-1:0])) == '0));

  a_r6_pull_follows_data: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 3'd2) |-> ((ppPullEn & ~rdData[PP_W-1:0]) == '0));

  a_r7_pull_off: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 3'd6 && !wrData[0]) |=> (ppPullEn == '0));

  a_r8_pull_indep: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(ppPullEn));

  a_r9_sync_delay: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 2'd2 && addr == 3'd4) |-> (rdData[OD_W-1:0] == $past(odPinIn, 2)));
endmodule

bind gpio_port gpio_port_chk #(.OD_W(OD_W), .PP_W(PP_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .rdData(rdData), .odPinIn(odPinIn), .odOutEn(odOutEn),
  .ppPeriphSel(ppPeriphSel), .ppOutEn(ppOutEn), .ppPullEn(ppPullEn)
);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
  localparam int OD_W = 3, PP_W = 4, DATA_W = 8;

  logic clk = 0, rstN = 0, wrEn = 0;
  logic [2:0] addr = 0;
  logic [DATA_W-1:0] wrData = 0, rdData;
  logic [OD_W-1:0] odPinIn = 0, odOutVal, odOutEn;
  logic [PP_W-1:0] ppPinIn = 0, ppPeriphSel = 0, ppPeriphVal = 0, ppPeriphEn = 0;
  logic [PP_W-1:0] ppOutVal, ppOutEn, ppPullEn;
  int nChk = 0, nFail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_port #(.OD_W(OD_W), .PP_W(PP_W), .DATA_W(DATA_W)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .odPinIn(odPinIn), .odOutVal(odOutVal), .odOutEn(odOutEn),
    .ppPinIn(ppPinIn), .ppPeriphSel(ppPeriphSel), .ppPeriphVal(ppPeriphVal),
    .ppPeriphEn(ppPeriphEn), .ppOutVal(ppOutVal), .ppOutEn(ppOutEn), .ppPullEn(ppPullEn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wrEn = 1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DATA_W-1:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    rd(3'd0, v); chk("R1 od data", v, 8'h07);
    rd(3'd1, v); chk("R1 od dir", v, 0);
    rd(3'd2, v); chk("R1 pp data", v, 8'h0F);
    rd(3'd3, v); chk("R1 pp dir", v, 0);
    rd(3'd6, v); chk("R1 ctrl", v, 0);
    chk("R1 od en", odOutEn, 0);
    chk("R1 pp en", ppOutEn, 0);
    chk("R1 pull", ppPullEn, 0);

    // Push-pull sweep: R2 R3 R5 R6 R7
    for (int pu = 0; pu < 2; pu++) begin
      wr(3'd6, 8'(pu));
      rd(3'd6, v); chk("R2 ctrl readback", v, pu);
      for (int d = 0; d < 16; d++) begin
        wr(3'd2, 8'(d));
        for (int r = 0; r < 16; r++) begin
          wr(3'd3, 8'(r));
          rd(3'd2, v); chk("R2 pp data readback", v, d);
          rd(3'd3, v); chk("R2 pp dir readback", v, r);
          chk("R3 pp out enable", ppOutEn, r);
          chk("R5 pp out value", ppOutVal, d);
          chk(pu ? "R6 pull select" : "R7 pull off", ppPullEn, pu ? d : 0);
        end
      end
    end

    // Open-drain sweep: R4
    for (int d = 0; d < 8; d++) begin
      wr(3'd0, 8'(d));
      for (int r = 0; r < 8; r++) begin
        wr(3'd1, 8'(r));
        chk("R4 od enable", odOutEn, 32'(r & ~d & 7));
        chk("R4 od value", odOutVal, 0);
      end
    end

    // R8 peripheral hand-over
    wr(3'd6, 8'h01); wr(3'd2, 8'h0A); wr(3'd3, 8'h0F);
    @(negedge clk);
    ppPeriphSel = 4'b0110; ppPeriphVal = 4'b0101; ppPeriphEn = 4'b0011;
    #1;
    chk("R8 periph value", ppOutVal, 4'b1100);
    chk("R8 periph enable", ppOutEn, 4'b1011);
    chk("R8 pull unchanged", ppPullEn, 4'b1010);
    ppPeriphSel = 0;

    // R9 synchronizer latency
    @(negedge clk);
    ppPinIn = 4'b1001; odPinIn = 3'b101;
    @(negedge clk);
    rd(3'd5, v); chk("R9 pp after one edge", v, 0);
    rd(3'd4, v); chk("R9 od after one edge", v, 0);
    @(negedge clk);
    rd(3'd5, v); chk("R9 pp after two edges", v, 8'h09);
    rd(3'd4, v); chk("R9 od after two edges", v, 8'h05);

    // R10 read-only and unmapped addresses
    wr(3'd4, 8'hFF); wr(3'd5, 8'hFF); wr(3'd7, 8'hFF);
    rd(3'd4, v); chk("R10 od pin unchanged", v, 8'h05);
    rd(3'd5, v); chk("R10 pp pin unchanged", v, 8'h09);
    rd(3'd7, v); chk("R10 addr7 reads zero", v, 0);
    rd(3'd2, v); chk("R10 pp data kept", v, 8'h0A);
    rd(3'd3, v); chk("R10 pp dir kept", v, 8'h0F);
    rd(3'd0, v); chk("R10 od data kept", v, 8'h07);
    rd(3'd1, v); chk("R10 od dir kept", v, 8'h07);
    rd(3'd6, v); chk("R10 ctrl kept", v, 8'h01);

    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule